// File: doc/BRIEF.md
# Multithreaded Issue Slot Scheduler

This block chooses, on every clock cycle, which of several hardware threads may place one instruction into a shared single-issue pipeline. Each cycle is one issue slot. At every clock edge the block makes one decision from the inputs present at that edge. It registers three outputs: a valid strobe, the chosen thread number and a bubble flag. The registered thread number is meant to travel down the pipeline with the instruction, so that each later stage reads and writes the state of the right thread.

Three run-time policies are available. The fixed policy rotates ownership of the slots over the threads in a fixed order. The table policy follows a software-loaded list of slot owners that the block steps through cyclically. The priority policy grants the ready thread that carries the highest software-set priority, and breaks ties in rotation. Under the fixed and table policies, a slot whose owner is not ready becomes an explicit bubble; the slot is never handed to another thread.

Top module: `issue_sched`

## Requirements
- R1: While rst_n is low, and right after it rises, issue_vld=0, bubble=0 and issue_tid=0. Reset also sets the slot pointer to entry 0, loads slot-table entry i with thread i mod NTHR, and records thread NTHR-1 as the last priority grant.
- R2: With mode_sel=0 (fixed), the slot owner at the k-th clock edge after reset is thread k mod NTHR. When that owner is ready, issue_vld=1 and issue_tid is the owner after that edge.
- R3: Under the fixed or table policy, when the slot owner's thr_ready bit (bit i is thread i) is low, the next outputs are issue_vld=0, bubble=1 and issue_tid equal to the owner. No other thread is granted.
- R4: A slot pointer moves through 0..SLOTS-1 cyclically, one step per clock edge, whatever the mode. With mode_sel=1 (table), the owner is the table entry the pointer selects.
- R5: When tbl_we is high at an edge, tbl_tid is written into entry tbl_addr at that edge. The slot decided at the same edge still sees the old entry; later slots see the new one.
- R6: With mode_sel=2 (priority), the ready thread with the largest priority value is granted. Thread i's priority is prio_flat[2i+1:2i], and a larger value means more urgent.
- R7: Under the priority policy, ties between ready threads are decided in rotation, starting with the thread after the last priority grant. Only priority-policy grants update that record.
- R8: Under the priority policy with no ready thread, the next outputs are issue_vld=0, bubble=1 and issue_tid=0.
- R9: A change of mode_sel applies to the decision made at the first edge where the new value is present. It does not apply earlier.
- R10: mode_sel=3 behaves exactly as the fixed policy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_ready | input | NTHR | Bit i set when thread i can issue |
| mode_sel | input | 2 | 0 fixed, 1 table, 2 priority, 3 as fixed |
| tbl_we | input | 1 | Slot-table write enable |
| tbl_addr | input | log2(SLOTS) | Slot-table entry to write |
| tbl_tid | input | log2(NTHR) | Thread number to store |
| prio_flat | input | NTHR*PRIO_W | Per-thread priorities, thread i at bits [PRIO_W*i +: PRIO_W] |
| issue_vld | output | 1 | A thread issues in this slot |
| issue_tid | output | log2(NTHR) | Thread owning this slot |
| bubble | output | 1 | This slot carries a pipeline bubble |

## Verification
The bench builds the block with its defaults: four threads, an eight-entry slot table and two-bit priorities. Because the table is twice as long as the thread count, the slot pointer wraps separately from the fixed rotation. A single run therefore reaches both wrap points, a reset-value table entry next to rewritten entries, and a write that lands on the entry being read in the same cycle. Two-bit priorities allow both a three-way spread and a tie between two threads, so the bench can check strict priority and also rotation among equal priorities.

// File: rtl/sched_pkg.sv
package sched_pkg;
    typedef enum logic [1:0] {
        MODE_FIXED = 2'd0,
        MODE_TABLE = 2'd1,
        MODE_PRIO  = 2'd2,
        MODE_RSVD  = 2'd3
    } sched_mode_e;
endpackage

// File: rtl/slot_table.sv
module slot_table #(
    parameter int NTHR  = 4,
    parameter int SLOTS = 8,
    localparam int AW   = $clog2(SLOTS),
    localparam int TW   = $clog2(NTHR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [TW-1:0] wtid,
    input  logic [AW-1:0] raddr,
    output logic [TW-1:0] rtid
);
    logic [TW-1:0] ent_d [SLOTS];
    logic [TW-1:0] ent_q [SLOTS];

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (we) begin
            ent_d[waddr] = wtid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                ent_q[i] <= TW'(i % NTHR);
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    // read returns the stored entry, so a same-edge write is seen one slot later
    assign rtid = ent_q[raddr];
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int NTHR   = 4,
    parameter int PRIO_W = 2,
    localparam int TW    = $clog2(NTHR)
) (
    input  logic [NTHR-1:0]        ready,
    input  logic [NTHR*PRIO_W-1:0] prio_flat,
    input  logic [TW-1:0]          last,
    output logic                   found,
    output logic [TW-1:0]          pick
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        found  = 1'b0;
        pick   = '0;
        best_p = '0;
        // walk in rotation order after 'last'; strict compare keeps the earliest on ties
        for (int k = 1; k <= NTHR; k++) begin
            int idx;
            idx = (int'(last) + k) % NTHR;
            if (ready[idx] && (!found || prio_flat[idx*PRIO_W +: PRIO_W] > best_p)) begin
                found  = 1'b1;
                pick   = TW'(idx);
                best_p = prio_flat[idx*PRIO_W +: PRIO_W];
            end
        end
    end

    always_comb begin
        if (found) begin
            // R6
            pick_ready_chk: assert (ready[pick]);
            for (int j = 0; j < NTHR; j++) begin
                if (ready[j]) begin
                    // R6
                    pick_top_chk: assert (prio_flat[j*PRIO_W +: PRIO_W]
                                          <= prio_flat[pick*PRIO_W +: PRIO_W]);
                end
            end
        end else begin
            // R8
            none_ready_chk: assert (ready == '0);
        end
    end
endmodule

// File: rtl/issue_sched.sv
module issue_sched
    import sched_pkg::*;
#(
    parameter int NTHR   = 4,
    parameter int SLOTS  = 8,
    parameter int PRIO_W = 2,
    localparam int AW    = $clog2(SLOTS),
    localparam int TW    = $clog2(NTHR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NTHR-1:0]        thr_ready,
    input  logic [1:0]             mode_sel,
    input  logic                   tbl_we,
    input  logic [AW-1:0]          tbl_addr,
    input  logic [TW-1:0]          tbl_tid,
    input  logic [NTHR*PRIO_W-1:0] prio_flat,
    output logic                   issue_vld,
    output logic [TW-1:0]          issue_tid,
    output logic                   bubble
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [TW-1:0] last;
        logic          vld;
        logic          bub;
        logic [TW-1:0] tid;
    } state_t;

    state_t st_d, st_q;

    logic [TW-1:0] tbl_owner;
    logic          pp_found;
    logic [TW-1:0] pp_pick;
    logic [TW-1:0] fix_owner;
    sched_mode_e   mode;

    slot_table #(.NTHR(NTHR), .SLOTS(SLOTS)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wtid  (tbl_tid),
        .raddr (st_q.ptr),
        .rtid  (tbl_owner)
    );

    prio_pick #(.NTHR(NTHR), .PRIO_W(PRIO_W)) u_pick (
        .ready     (thr_ready),
        .prio_flat (prio_flat),
        .last      (st_q.last),
        .found     (pp_found),
        .pick      (pp_pick)
    );

    assign mode      = sched_mode_e'(mode_sel);
    assign fix_owner = TW'(int'(st_q.ptr) % NTHR);

    always_comb begin
        logic [TW-1:0] owner;
        st_d     = st_q;
        st_d.ptr = (st_q.ptr == AW'(SLOTS - 1)) ? '0 : st_q.ptr + 1'b1;
        owner    = (mode == MODE_TABLE) ? tbl_owner : fix_owner;
        if (mode == MODE_PRIO) begin
            st_d.vld = pp_found;
            st_d.bub = !pp_found;
            st_d.tid = pp_found ? pp_pick : '0;
            if (pp_found) begin
                st_d.last = pp_pick;
            end
        end else begin
            st_d.vld = thr_ready[owner];
            st_d.bub = !thr_ready[owner];
            st_d.tid = owner;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr  <= '0;
            st_q.last <= TW'(NTHR - 1);
            st_q.vld  <= 1'b0;
            st_q.bub  <= 1'b0;
            st_q.tid  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_vld = st_q.vld;
    assign issue_tid = st_q.tid;
    assign bubble    = st_q.bub;

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.ptr == (($past(st_q.ptr) == AW'(SLOTS - 1)) ? '0 : $past(st_q.ptr) + 1'b1)));

    // R2
    fixed_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(mode_sel) == 2'd0 && $past(mode_sel, 2) == 2'd0)
        |-> (issue_tid == TW'($past(issue_tid) + 1'b1)));

    // R3
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && issue_vld) |-> ((($past(thr_ready) >> issue_tid) & 1) != 0));

    // R8
    vld_bub_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_vld && bubble));

    // R8
    prio_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && thr_ready == '0) |=> (bubble && issue_tid == '0));
endmodule

// File: tb/sim_issue_sched.sv
module sim_issue_sched;
    localparam int NTHR = 4, SLOTS = 8, PRIO_W = 2;
    localparam int NV = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  thr_ready = '0;
    logic [1:0]  mode_sel = '0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_addr = '0;
    logic [1:0]  tbl_tid = '0;
    logic [7:0]  prio_flat = '0;
    logic        issue_vld;
    logic [1:0]  issue_tid;
    logic        bubble;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    issue_sched #(.NTHR(NTHR), .SLOTS(SLOTS), .PRIO_W(PRIO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .mode_sel(mode_sel),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_tid(tbl_tid),
        .prio_flat(prio_flat), .issue_vld(issue_vld), .issue_tid(issue_tid),
        .bubble(bubble)
    );

    // {mode, ready, we, addr, wtid, exp_vld, exp_tid, exp_bub}
    localparam logic [15:0] VEC [NV] = '{
        {2'd0, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd0, 1'b0},
        {2'd0, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd1, 1'b0},
        {2'd0, 4'b0011, 1'b0, 3'd0, 2'd0, 1'b0, 2'd2, 1'b1},
        {2'd0, 4'b1000, 1'b0, 3'd0, 2'd0, 1'b1, 2'd3, 1'b0},
        {2'd0, 4'b0001, 1'b0, 3'd0, 2'd0, 1'b1, 2'd0, 1'b0},
        {2'd2, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd0, 1'b0},
        {2'd2, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd1, 1'b0},
        {2'd2, 4'b0101, 1'b0, 3'd0, 2'd0, 1'b1, 2'd2, 1'b0},
        {2'd2, 4'b0000, 1'b0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b1},
        {2'd2, 4'b1001, 1'b0, 3'd0, 2'd0, 1'b1, 2'd3, 1'b0},
        {2'd0, 4'b1111, 1'b1, 3'd3, 2'd1, 1'b1, 2'd2, 1'b0},
        {2'd1, 4'b1111, 1'b1, 3'd4, 2'd2, 1'b1, 2'd1, 1'b0},
        {2'd1, 4'b1111, 1'b1, 3'd4, 2'd3, 1'b1, 2'd2, 1'b0},
        {2'd1, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd1, 1'b0},
        {2'd1, 4'b1011, 1'b0, 3'd0, 2'd0, 1'b0, 2'd2, 1'b1},
        {2'd1, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd3, 1'b0},
        {2'd1, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd0, 1'b0},
        {2'd1, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd1, 1'b0},
        {2'd1, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd2, 1'b0},
        {2'd1, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd1, 1'b0},
        {2'd1, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd3, 1'b0},
        {2'd3, 4'b1111, 1'b0, 3'd0, 2'd0, 1'b1, 2'd1, 1'b0}
    };

    function automatic string req_of(int i);
        case (i)
            2, 14:          return "R3";
            5:              return "R9";
            6, 7, 9:        return "R7";
            8:              return "R8";
            11, 12, 19, 20: return "R5";
            13, 15, 16, 17, 18: return "R4";
            21:             return "R10";
            default:        return "R2";
        endcase
    endfunction

    task automatic check(string req, logic ev, logic [1:0] et, logic eb);
        n_run++;
        if (issue_vld !== ev || issue_tid !== et || bubble !== eb) begin
            n_fail++;
            $display("FAIL %s: vld/tid/bub got %b/%0d/%b expected %b/%0d/%b",
                     req, issue_vld, issue_tid, bubble, ev, et, eb);
        end
    endtask

    task automatic step(logic [1:0] m, logic [3:0] rdy, string req,
                        logic ev, logic [1:0] et, logic eb);
        mode_sel  = m;
        thr_ready = rdy;
        @(negedge clk);
        check(req, ev, et, eb);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 2'd0, 1'b0);
        rst_n = 1'b1;
        check("R1", 1'b0, 2'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            mode_sel  = VEC[i][15:14];
            thr_ready = VEC[i][13:10];
            tbl_we    = VEC[i][9];
            tbl_addr  = VEC[i][8:6];
            tbl_tid   = VEC[i][5:4];
            @(negedge clk);
            tbl_we = 1'b0;
            check(req_of(i), VEC[i][3], VEC[i][2:1], VEC[i][0]);
        end

        // R6: thread0=1, thread1=3, thread2=3, thread3=0
        prio_flat = 8'b00_11_11_01;
        step(2'd2, 4'b1111, "R6", 1'b1, 2'd1, 1'b0);
        step(2'd2, 4'b1111, "R7", 1'b1, 2'd2, 1'b0);
        step(2'd2, 4'b1111, "R7", 1'b1, 2'd1, 1'b0);
        step(2'd2, 4'b1001, "R6", 1'b1, 2'd0, 1'b0);
        step(2'd2, 4'b1000, "R6", 1'b1, 2'd3, 1'b0);

        // R1: reset in mid-run restores pointer, table and rotation record
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 1'b0, 2'd0, 1'b0);
        rst_n = 1'b1;
        prio_flat = '0;
        step(2'd0, 4'b1111, "R1", 1'b1, 2'd0, 1'b0);
        step(2'd1, 4'b1111, "R1", 1'b1, 2'd1, 1'b0);
        step(2'd2, 4'b1111, "R1", 1'b1, 2'd0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule